// File: doc/BRIEF.md
# Platform Reset Pulse Generator

This block produces a single reset pulse toward the platform controller when it is asked to. It can produce two kinds of pulse. A cold pulse pulls the power-good line low for a long, fixed time and then lets it go. A warm pulse pulls the active-low reset request line low for a shorter, fixed time and leaves power-good alone. The power sequencer owns the levels of both lines. This block passes those levels through to its outputs and overrides one of them only while a pulse is running.

A one-cycle start strobe asks for a pulse, and a select input chooses the kind. If the line that the chosen kind would pull low is already low, the request does nothing. A busy flag covers the whole pulse, and any strobe that arrives while it is high is dropped. Both pulse widths are parameters counted in clock cycles. The defaults give 100 µs for a cold pulse and 10 µs for a warm pulse at 125 MHz. Those widths sit well above the minimums the controller needs, which are about 91 µs for a cold pulse and 500 ns for a warm one.

Top module: `rst_pulse_gen`

## Requirements
- R1: A strobe with select high, sampled while the power-good level input is high, drives `pwr_ok_o` low starting the cycle after the strobe edge. It stays low for exactly `COLD_LOW_CYCLES` cycles (default 12500) and then follows its level input again.
- R2: A strobe with select low, sampled while the reset-request level input is high, drives `rst_in_n_o` low starting the cycle after the strobe edge. It stays low for exactly `WARM_LOW_CYCLES` cycles (default 1250) and then follows its level input again.
- R3: A cold pulse never pulls `rst_in_n_o` low, and a warm pulse never pulls `pwr_ok_o` low. While a pulse runs, the line it does not target keeps following its level input.
- R4: A cold request that arrives while `pwr_ok_lvl_i` is low does nothing. `busy_o` stays low and both outputs keep following their level inputs.
- R5: A warm request that arrives while `rst_in_n_lvl_i` is low does nothing. `busy_o` stays low and both outputs keep following their level inputs.
- R6: `busy_o` is high in exactly the cycles in which one of the two lines is being forced low. It is never high when neither line is forced.
- R7: A strobe that arrives while `busy_o` is high is dropped, whatever the select value. It neither lengthens the running pulse nor changes its kind.
- R8: When neither line is forced, and also during reset, each output equals its level input as sampled at the previous clock edge. Reset leaves `busy_o` low.
- R9: A strobe sampled in the first cycle after `busy_o` falls is accepted, so one pulse can follow another with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| cold_sel_i | input | 1 | Selects the pulse kind: 1 = cold, 0 = warm |
| pwr_ok_lvl_i | input | 1 | Power-good level as driven by the sequencer |
| rst_in_n_lvl_i | input | 1 | Active-low reset request level as driven by the sequencer |
| pwr_ok_o | output | 1 | Power-good value sent to the controller |
| rst_in_n_o | output | 1 | Reset request value sent to the controller |
| busy_o | output | 1 | High for the whole duration of a pulse |

## Verification
Several properties are checked by assertions on every cycle:
- `busy_o` agrees with the set of forced lines, and at most one line is forced at a time.
- While busy, the forced line does not change.
- Each unforced output follows its level input one cycle later.
- A request aimed at a line that is already low leaves the block idle.

The exact cold and warm widths counted against the parameters need the bench's scenarios, and so do the untouched second line during each kind of pulse, the strobe dropped in mid-pulse, and the back-to-back restart.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_COLD = 2'd1,
    PH_WARM = 2'd2
  } phase_e;

  localparam int unsigned LINE_PWROK = 0;
  localparam int unsigned LINE_RSTIN = 1;
  localparam int unsigned NUM_LINES  = 2;
endpackage

// File: rtl/rpg_width_timer.sv
module rpg_width_timer #(
  parameter int unsigned COLD_LOW_CYCLES = 12500,
  parameter int unsigned WARM_LOW_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic load_cold_i,
  output logic done_o
);
  localparam int unsigned MAX_W = (COLD_LOW_CYCLES > WARM_LOW_CYCLES) ?
                                  COLD_LOW_CYCLES : WARM_LOW_CYCLES;
  localparam int unsigned CW = $clog2(MAX_W + 1);
  localparam logic [CW-1:0] COLD_LOAD = CW'(COLD_LOW_CYCLES - 1);
  localparam logic [CW-1:0] WARM_LOAD = CW'(WARM_LOW_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_cold_i ? COLD_LOAD : WARM_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

  // The remaining count never goes above the longest width.
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= COLD_LOAD || cnt_q <= WARM_LOAD);
endmodule

// File: rtl/rpg_req_ctrl.sv
module rpg_req_ctrl
  import rpg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   cold_sel_i,
  input  logic   pwr_ok_lvl_i,
  input  logic   rst_in_n_lvl_i,
  input  logic   timer_done_i,
  output phase_e phase_nxt_o,
  output logic   load_o,
  output logic   load_cold_o,
  output logic   busy_o
);
  phase_e phase_q, phase_nxt;
  logic   busy_q;

  always_comb begin
    phase_nxt   = phase_q;
    load_o      = 1'b0;
    load_cold_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          if (cold_sel_i && pwr_ok_lvl_i) begin
            phase_nxt   = PH_COLD;
            load_o      = 1'b1;
            load_cold_o = 1'b1;
          end else if (!cold_sel_i && rst_in_n_lvl_i) begin
            phase_nxt = PH_WARM;
            load_o    = 1'b1;
          end
        end
      end
      PH_COLD, PH_WARM: begin
        if (timer_done_i) phase_nxt = PH_IDLE;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      busy_q  <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      busy_q  <= (phase_nxt != PH_IDLE);
    end
  end

  assign phase_nxt_o = phase_nxt;
  assign busy_o      = busy_q;

  // A load happens only from idle.
  assert_load_from_idle_R7: assert property (@(posedge clk) disable iff (rst)
    load_o |-> !busy_q);
endmodule

// File: rtl/rpg_line_override.sv
module rpg_line_override #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] force_low_i,
  output logic [LINES-1:0] line_o,
  output logic [LINES-1:0] forced_o
);
  logic [LINES-1:0] line_q;
  logic [LINES-1:0] forced_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        line_q[g]   <= lvl_i[g];
        forced_q[g] <= 1'b0;
      end else begin
        line_q[g]   <= force_low_i[g] ? 1'b0 : lvl_i[g];
        forced_q[g] <= force_low_i[g];
      end
    end

    // An unforced line follows its level input one cycle later.
    assert_follow_level_R8: assert property (@(posedge clk) disable iff (rst)
      !forced_q[g] |-> line_q[g] == $past(lvl_i[g]));

    assert_forced_low_R1: assert property (@(posedge clk) disable iff (rst)
      forced_q[g] |-> !line_q[g]);
  end

  // Never more than one line overridden.
  assert_single_force_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(forced_q) <= 1);

  assign line_o   = line_q;
  assign forced_o = forced_q;
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
  import rpg_pkg::*;
#(
  parameter int unsigned COLD_LOW_CYCLES = 12500,
  parameter int unsigned WARM_LOW_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cold_sel_i,
  input  logic pwr_ok_lvl_i,
  input  logic rst_in_n_lvl_i,
  output logic pwr_ok_o,
  output logic rst_in_n_o,
  output logic busy_o
);
  phase_e               phase_nxt;
  logic                 load, load_cold, timer_done;
  logic [NUM_LINES-1:0] lvl, force_low, line, forced;

  rpg_width_timer #(
    .COLD_LOW_CYCLES(COLD_LOW_CYCLES),
    .WARM_LOW_CYCLES(WARM_LOW_CYCLES)
  ) i_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_cold_i(load_cold),
    .done_o     (timer_done)
  );

  rpg_req_ctrl i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .cold_sel_i    (cold_sel_i),
    .pwr_ok_lvl_i  (pwr_ok_lvl_i),
    .rst_in_n_lvl_i(rst_in_n_lvl_i),
    .timer_done_i  (timer_done),
    .phase_nxt_o   (phase_nxt),
    .load_o        (load),
    .load_cold_o   (load_cold),
    .busy_o        (busy_o)
  );

  always_comb begin
    lvl                   = '0;
    force_low             = '0;
    lvl[LINE_PWROK]       = pwr_ok_lvl_i;
    lvl[LINE_RSTIN]       = rst_in_n_lvl_i;
    force_low[LINE_PWROK] = (phase_nxt == PH_COLD);
    force_low[LINE_RSTIN] = (phase_nxt == PH_WARM);
  end

  rpg_line_override #(.LINES(NUM_LINES)) i_override (
    .clk        (clk),
    .rst        (rst),
    .lvl_i      (lvl),
    .force_low_i(force_low),
    .line_o     (line),
    .forced_o   (forced)
  );

  assign pwr_ok_o   = line[LINE_PWROK];
  assign rst_in_n_o = line[LINE_RSTIN];

  assert_busy_matches_force_R6: assert property (@(posedge clk) disable iff (rst)
    busy_o == (|forced));

  assert_cold_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && cold_sel_i && !pwr_ok_lvl_i) |=> !busy_o);

  assert_warm_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !cold_sel_i && !rst_in_n_lvl_i) |=> !busy_o);

  assert_kind_held_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(forced));
endmodule

// File: tb/test_rst_pulse_gen.sv
`timescale 1ns/1ps
module test_rst_pulse_gen;
  localparam int COLD_W = 12500;
  localparam int WARM_W = 1250;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, cold_sel_i = 1'b0;
  logic pwr_ok_lvl_i = 1'b1, rst_in_n_lvl_i = 1'b1;
  logic pwr_ok_o, rst_in_n_o, busy_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rst_pulse_gen i_rst_pulse_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .cold_sel_i(cold_sel_i),
    .pwr_ok_lvl_i(pwr_ok_lvl_i), .rst_in_n_lvl_i(rst_in_n_lvl_i),
    .pwr_ok_o(pwr_ok_o), .rst_in_n_o(rst_in_n_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Issue a strobe and measure the pulse until busy drops.
  // mid_at >= 0 drives an extra strobe of the other kind at that cycle.
  task automatic run_pulse(input bit cold, input int mid_at,
                           output int busy_n, output int pw_low, output int ri_low,
                           output bit first_busy);
    busy_n = 0; pw_low = 0; ri_low = 0;
    start_i = 1'b1; cold_sel_i = cold;
    @(negedge clk);
    start_i = 1'b0;
    first_busy = busy_o;
    while (busy_o && busy_n < 40000) begin
      busy_n++;
      if (!pwr_ok_o) pw_low++;
      if (!rst_in_n_o) ri_low++;
      if (busy_n == mid_at) begin
        start_i = 1'b1; cold_sel_i = ~cold;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  task automatic t_reset;
    check(busy_o == 1'b0, "R8", "busy in reset", busy_o, 0);
    check(pwr_ok_o == 1'b1, "R8", "pwr_ok in reset", pwr_ok_o, 1);
    check(rst_in_n_o == 1'b1, "R8", "rst_in in reset", rst_in_n_o, 1);
  endtask

  task automatic t_cold;
    int b, p, r; bit f;
    run_pulse(1'b1, -1, b, p, r, f);
    check(f, "R1", "cold starts next cycle", f, 1);
    check(p == COLD_W, "R1", "cold low width", p, COLD_W);
    check(b == COLD_W, "R6", "cold busy width", b, COLD_W);
    check(r == 0, "R3", "rst_in untouched by cold", r, 0);
    check(pwr_ok_o == 1'b1, "R1", "pwr_ok restored", pwr_ok_o, 1);
  endtask

  task automatic t_warm;
    int b, p, r; bit f;
    run_pulse(1'b0, -1, b, p, r, f);
    check(f, "R2", "warm starts next cycle", f, 1);
    check(r == WARM_W, "R2", "warm low width", r, WARM_W);
    check(b == WARM_W, "R6", "warm busy width", b, WARM_W);
    check(p == 0, "R3", "pwr_ok untouched by warm", p, 0);
    check(rst_in_n_o == 1'b1, "R2", "rst_in restored", rst_in_n_o, 1);
  endtask

  task automatic t_cold_ignored;
    pwr_ok_lvl_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; cold_sel_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b0, "R4", "busy after ignored cold", busy_o, 0);
    check(rst_in_n_o == 1'b1, "R4", "rst_in after ignored cold", rst_in_n_o, 1);
    @(negedge clk);
    check(busy_o == 1'b0, "R4", "still idle", busy_o, 0);
    pwr_ok_lvl_i = 1'b1;
    @(negedge clk);
    check(pwr_ok_o == 1'b1, "R4", "pwr_ok follows again", pwr_ok_o, 1);
  endtask

  task automatic t_warm_ignored;
    rst_in_n_lvl_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; cold_sel_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b0, "R5", "busy after ignored warm", busy_o, 0);
    check(pwr_ok_o == 1'b1, "R5", "pwr_ok after ignored warm", pwr_ok_o, 1);
    check(rst_in_n_o == 1'b0, "R5", "rst_in follows low level", rst_in_n_o, 0);
    rst_in_n_lvl_i = 1'b1;
    @(negedge clk);
    check(rst_in_n_o == 1'b1, "R5", "rst_in follows again", rst_in_n_o, 1);
  endtask

  task automatic t_strobe_while_busy;
    int b, p, r; bit f;
    run_pulse(1'b1, 200, b, p, r, f);
    check(b == COLD_W, "R7", "busy not extended", b, COLD_W);
    check(r == 0, "R7", "no warm pulse while busy", r, 0);
    run_pulse(1'b0, 10, b, p, r, f);
    check(b == WARM_W, "R7", "warm not extended", b, WARM_W);
    check(p == 0, "R7", "no cold pulse while busy", p, 0);
  endtask

  task automatic t_passthrough;
    pwr_ok_lvl_i = 1'b0; rst_in_n_lvl_i = 1'b1;
    @(negedge clk);
    check(pwr_ok_o == 1'b0 && rst_in_n_o == 1'b1, "R8", "follow 0/1",
          {pwr_ok_o, rst_in_n_o}, 1);
    pwr_ok_lvl_i = 1'b1; rst_in_n_lvl_i = 1'b0;
    @(negedge clk);
    check(pwr_ok_o == 1'b1 && rst_in_n_o == 1'b0, "R8", "follow 1/0",
          {pwr_ok_o, rst_in_n_o}, 2);
    rst_in_n_lvl_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_back_to_back;
    int b, p, r; bit f;
    run_pulse(1'b0, -1, b, p, r, f);
    // run_pulse returns in the first idle cycle; strobe again at once.
    run_pulse(1'b1, -1, b, p, r, f);
    check(f, "R9", "back-to-back accepted", f, 1);
    check(p == COLD_W, "R9", "back-to-back cold width", p, COLD_W);
  endtask

  // Warm pulse while the sequencer moves power-good: output tracks it.
  task automatic t_other_line_follows;
    int seen_low = 0;
    start_i = 1'b1; cold_sel_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    pwr_ok_lvl_i = 1'b0;
    @(negedge clk);
    if (!pwr_ok_o && busy_o) seen_low = 1;
    check(seen_low == 1, "R3", "pwr_ok follows level during warm", pwr_ok_o, 0);
    pwr_ok_lvl_i = 1'b1;
    repeat (WARM_W + 2) @(negedge clk);
    check(busy_o == 1'b0 && pwr_ok_o == 1'b1, "R3", "idle after warm", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold();
    t_warm();
    t_cold_ignored();
    t_warm_ignored();
    t_strobe_while_busy();
    t_passthrough();
    t_back_to_back();
    t_other_line_follows();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule